// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block gathers a bank of interrupt lines, ranks the ones that are both pending and enabled, and signals a CPU on one of two outputs: a normal interrupt request (`cpu_irq`) and a fast interrupt request (`cpu_fiq`). Each line has its own configuration word that sets a 5-bit priority, chooses edge or level sensing, and routes the line to the fast output. When an output asserts, the controller freezes the winning line number and its priority in a source register. That value stays fixed until software writes an acknowledge. Only then can a new winner be taken.

A parameter selects whether the bank is first-level or secondary. Only a first-level bank honours fast-interrupt routing; in a secondary bank every line goes to the normal output. Banks cascade: the normal output of a secondary bank drives one line of a first-level bank. Software then acknowledges the secondary bank first and the first-level bank after it. A global mask holds both outputs low until software clears it.

Register map (byte offsets):

| Offset | Register |
|---|---|
| 0x00 | pending |
| 0x04 | mask |
| 0x10 | IRQ source |
| 0x14 | FIQ source |
| 0x18 | acknowledge control |
| 0x1C + 4·n | configuration word for line n |
| 0xA0 | global mask |

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, the mask register (0x04) reads all ones, the global mask (0xA0) reads 1, every per-line configuration word reads 0, and both `cpu_irq` and `cpu_fiq` are low.
- R2: In the mask register, bit n = 1 keeps line n from being taken and bit n = 0 enables it. A masked line still shows in the pending register (0x00).
- R3: The configuration word for line n is at offset 0x1C + 4·n. Its bit 0 routes the line to the fast output, bit 1 selects edge sensing (1) or level sensing (0), and bits 6:2 hold the priority. All other bits read 0.
- R4: Among the enabled pending lines of one output, the line with the numerically lowest priority wins, and priority 0 ranks highest. On a priority tie, the lowest line number wins.
- R5: Each source register holds the winning line number in bits 4:0 and its priority in bits 12:8. The IRQ source is at 0x10 and the FIQ source is at 0x14. Once the matching output asserts, the value does not change, even if a higher-priority line arrives, until that output is acknowledged.
- R6: A write to the control register (0x18) with bit 0 set acknowledges the normal output, and with bit 1 set acknowledges the fast output. Each bit releases only its own output, after which a new winner can be taken.
- R7: A level-sensed line's pending bit follows its input. An edge-sensed line latches a rising edge, and the latch holds until that line is acknowledged as the current winner.
- R8: A write to the pending register clears each latched edge for which the written bit is 0. Writing 0 clears every latch.
- R9: While the global mask bit 0 is 1, both outputs stay low. Clearing it lets a pending winner drive its output.
- R10: In a secondary bank, bit 0 of a configuration word always reads 0. Every line of a secondary bank drives only `cpu_irq`, and `cpu_fiq` stays low.
- R11: A secondary bank's `cpu_irq` can drive a line of a first-level bank. The first-level bank reports that line as its winner. Both outputs go low after the secondary bank is acknowledged and then the first-level bank is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Interrupt request inputs, one per line |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, one cycle after the address |
| cpu_irq | output | 1 | Normal interrupt request to the CPU |
| cpu_fiq | output | 1 | Fast interrupt request to the CPU (first-level bank only) |

## Verification
The bench builds two instances, both with 32 lines and 5-bit priorities. The main instance uses `FIRST_LEVEL = 1`, which brings fast-interrupt routing and the split between the two outputs within reach. The second instance uses `FIRST_LEVEL = 0`, which exercises the forced routing to the normal output and the discarded routing bit. The second instance's `cpu_irq` drives line 0 of the main instance, so the two-step acknowledge order of a cascade is tested across both parameter variants.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int OFS_PEND  = 'h00;
  localparam int OFS_MASK  = 'h04;
  localparam int OFS_ISRC  = 'h10;
  localparam int OFS_FSRC  = 'h14;
  localparam int OFS_CTRL  = 'h18;
  localparam int OFS_LVL   = 'h1C;
  localparam int OFS_GMASK = 'hA0;
  localparam int ACK_IRQ_BIT  = 0;
  localparam int ACK_FIQ_BIT  = 1;
  localparam int SRC_PRIO_LSB = 8;
  localparam int CFG_FIQ_BIT  = 0;
  localparam int CFG_TRIG_BIT = 1;
  localparam int CFG_PRIO_LSB = 2;
endpackage

// File: rtl/irqb_pend.sv
module irqb_pend #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] clr,
  input  logic         wr_en,
  input  logic [N-1:0] wr_keep,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q;
  logic [N-1:0] latch_d;
  logic [N-1:0] keep;

  assign keep    = wr_en ? wr_keep : '1;
  // Edge latch: keep the old value unless it is cleared, then add new rising edges.
  assign latch_d = (((pend & trig) & ~clr & keep) | (lines & ~prev_q)) & trig;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend   <= '0;
    end else begin
      prev_q <= lines;
      pend   <= latch_d | (lines & ~trig);
    end
  end

  // R7: an edge latch with no clear and no write stays set
  a_r7_edge_holds: assert property (@(posedge clk) disable iff (rst)
    (|(pend & trig & ~clr) && !wr_en && $stable(trig)) |=> |(pend & trig));
endmodule

// File: rtl/irqb_pick.sv
module irqb_pick #(
  parameter int N      = 32,
  parameter int PRIO_W = 5,
  parameter int LINE_W = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N-1:0]                cand,
  input  logic [N-1:0][PRIO_W-1:0]    prio,
  output logic                        any,
  output logic [LINE_W-1:0]           win_idx,
  output logic [PRIO_W-1:0]           win_prio
);
  // Scan upward; replace only on a strictly better priority, so ties keep the lower index.
  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_prio = '1;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!any || prio[i] < win_prio)) begin
        any      = 1'b1;
        win_idx  = LINE_W'(i);
        win_prio = prio[i];
      end
    end
  end

  // R4: the winner is always one of the candidates, with its own priority
  a_r4_win_eligible: assert property (@(posedge clk) disable iff (rst)
    any |-> (cand[win_idx] && prio[win_idx] == win_prio));
endmodule

// File: rtl/irqb_chan.sv
module irqb_chan #(
  parameter int LINE_W = 5,
  parameter int PRIO_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gmask_q,
  input  logic              gmask_nx,
  input  logic              cand_any,
  input  logic [LINE_W-1:0] cand_idx,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              ack,
  output logic              busy,
  output logic [LINE_W-1:0] line,
  output logic [PRIO_W-1:0] prio,
  output logic              out
);
  logic take;
  logic busy_d;

  assign take   = !busy && !ack && cand_any && !gmask_q;
  assign busy_d = ack ? 1'b0 : (busy | take);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      line <= '0;
      prio <= '0;
      out  <= 1'b0;
    end else begin
      busy <= busy_d;
      out  <= busy_d && !gmask_nx;
      if (take) begin
        line <= cand_idx;
        prio <= cand_prio;
      end
    end
  end

  // R5: winner stays frozen while held and not acknowledged
  a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && !ack) |=> (busy && $stable(line) && $stable(prio)));
  // R6: an acknowledge releases the channel
  a_r6_ack_release: assert property (@(posedge clk) disable iff (rst)
    (busy && ack) |=> !busy);
  // R9: a capture only follows an eligible candidate with the global mask open
  a_r9_capture_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cand_any && !gmask_q));
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irqb_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int PRIO_W      = 5,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter bit FIRST_LEVEL = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 cpu_irq,
  output logic                 cpu_fiq
);
  localparam int LINE_W   = $clog2(NUM_LINES);
  localparam int LVL_SPAN = 4 * NUM_LINES;

  logic [NUM_LINES-1:0]             mask_q, fiq_q, trig_q, pend;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
  logic                             gmask_q, gmask_nx;

  // Address decode
  logic            wr_pend, wr_mask, wr_ctrl, wr_gmask, wr_lvl;
  logic            lvl_hit;
  logic [ADDR_W:0] lvl_off;
  logic [LINE_W-1:0] lvl_idx;

  assign lvl_off  = {1'b0, bus_addr} - (ADDR_W+1)'(OFS_LVL);
  assign lvl_hit  = (bus_addr >= ADDR_W'(OFS_LVL)) && (int'(lvl_off) < LVL_SPAN) && (lvl_off[1:0] == 2'b00);
  assign lvl_idx  = lvl_off[LINE_W+1:2];
  assign wr_pend  = bus_wr && bus_addr == ADDR_W'(OFS_PEND);
  assign wr_mask  = bus_wr && bus_addr == ADDR_W'(OFS_MASK);
  assign wr_ctrl  = bus_wr && bus_addr == ADDR_W'(OFS_CTRL);
  assign wr_gmask = bus_wr && bus_addr == ADDR_W'(OFS_GMASK);
  assign wr_lvl   = bus_wr && lvl_hit;
  assign gmask_nx = wr_gmask ? bus_wdata[0] : gmask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      gmask_q <= 1'b1;
      fiq_q   <= '0;
      trig_q  <= '0;
      prio_q  <= '0;
    end else begin
      gmask_q <= gmask_nx;
      if (wr_mask) mask_q <= bus_wdata[NUM_LINES-1:0];
      if (wr_lvl) begin
        fiq_q[lvl_idx]  <= FIRST_LEVEL ? bus_wdata[CFG_FIQ_BIT] : 1'b0;
        trig_q[lvl_idx] <= bus_wdata[CFG_TRIG_BIT];
        prio_q[lvl_idx] <= bus_wdata[CFG_PRIO_LSB +: PRIO_W];
      end
    end
  end

  // Acknowledge and edge-latch clearing
  logic ack_irq, ack_fiq;
  logic irq_busy, fiq_busy;
  logic [LINE_W-1:0] irq_line, fiq_line;
  logic [PRIO_W-1:0] irq_prio, fiq_prio;
  logic [NUM_LINES-1:0] clr;

  assign ack_irq = wr_ctrl && bus_wdata[ACK_IRQ_BIT];
  assign ack_fiq = wr_ctrl && bus_wdata[ACK_FIQ_BIT];

  always_comb begin
    clr = '0;
    if (ack_irq && irq_busy) clr[irq_line] = 1'b1;
    if (ack_fiq && fiq_busy) clr[fiq_line] = 1'b1;
  end

  irqb_pend #(.N(NUM_LINES)) u_pend (
    .clk(clk), .rst(rst), .lines(irq_lines), .trig(trig_q), .clr(clr),
    .wr_en(wr_pend), .wr_keep(bus_wdata[NUM_LINES-1:0]), .pend(pend)
  );

  logic [NUM_LINES-1:0] elig;
  assign elig = pend & ~mask_q;

  // Normal request path
  logic              irq_any;
  logic [LINE_W-1:0] irq_widx;
  logic [PRIO_W-1:0] irq_wprio;

  irqb_pick #(.N(NUM_LINES), .PRIO_W(PRIO_W), .LINE_W(LINE_W)) u_pick_irq (
    .clk(clk), .rst(rst), .cand(elig & ~fiq_q), .prio(prio_q),
    .any(irq_any), .win_idx(irq_widx), .win_prio(irq_wprio)
  );

  irqb_chan #(.LINE_W(LINE_W), .PRIO_W(PRIO_W)) u_chan_irq (
    .clk(clk), .rst(rst), .gmask_q(gmask_q), .gmask_nx(gmask_nx),
    .cand_any(irq_any), .cand_idx(irq_widx), .cand_prio(irq_wprio), .ack(ack_irq),
    .busy(irq_busy), .line(irq_line), .prio(irq_prio), .out(cpu_irq)
  );

  // Fast request path, first-level banks only
  generate
    if (FIRST_LEVEL) begin : g_fiq
      logic              fiq_any;
      logic [LINE_W-1:0] fiq_widx;
      logic [PRIO_W-1:0] fiq_wprio;

      irqb_pick #(.N(NUM_LINES), .PRIO_W(PRIO_W), .LINE_W(LINE_W)) u_pick_fiq (
        .clk(clk), .rst(rst), .cand(elig & fiq_q), .prio(prio_q),
        .any(fiq_any), .win_idx(fiq_widx), .win_prio(fiq_wprio)
      );

      irqb_chan #(.LINE_W(LINE_W), .PRIO_W(PRIO_W)) u_chan_fiq (
        .clk(clk), .rst(rst), .gmask_q(gmask_q), .gmask_nx(gmask_nx),
        .cand_any(fiq_any), .cand_idx(fiq_widx), .cand_prio(fiq_wprio), .ack(ack_fiq),
        .busy(fiq_busy), .line(fiq_line), .prio(fiq_prio), .out(cpu_fiq)
      );
    end else begin : g_nofiq
      assign fiq_busy = 1'b0;
      assign fiq_line = '0;
      assign fiq_prio = '0;
      assign cpu_fiq  = 1'b0;
    end
  endgenerate

  // Registered read mux
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (lvl_hit)
      rd_word = DATA_W'({prio_q[lvl_idx], trig_q[lvl_idx], fiq_q[lvl_idx]});
    else if (bus_addr == ADDR_W'(OFS_PEND))  rd_word = DATA_W'(pend);
    else if (bus_addr == ADDR_W'(OFS_MASK))  rd_word = DATA_W'(mask_q);
    else if (bus_addr == ADDR_W'(OFS_ISRC))  rd_word = (DATA_W'(irq_prio) << SRC_PRIO_LSB) | DATA_W'(irq_line);
    else if (bus_addr == ADDR_W'(OFS_FSRC))  rd_word = (DATA_W'(fiq_prio) << SRC_PRIO_LSB) | DATA_W'(fiq_line);
    else if (bus_addr == ADDR_W'(OFS_GMASK)) rd_word = DATA_W'(gmask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_word;
  end

  // R9: global mask keeps both outputs quiet
  a_r9_gmask_quiet: assert property (@(posedge clk) disable iff (rst)
    gmask_q |-> (!cpu_irq && !cpu_fiq));
  // R10: a secondary bank never raises the fast output
  a_r10_no_fiq_secondary: assert property (@(posedge clk) disable iff (rst)
    (!FIRST_LEVEL) |-> !cpu_fiq);
endmodule

// File: tb/irq_bank_ctrl_tb.sv
`timescale 1ns/1ps
module irq_bank_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] lines = '0, sec_lines = '0;
  logic d_wr = 0, s_wr = 0;
  logic [7:0] d_addr = '0, s_addr = '0;
  logic [31:0] d_wdata = '0, s_wdata = '0, d_rdata, s_rdata;
  logic d_irq, d_fiq, s_irq, s_fiq;

  irq_bank_ctrl #(.FIRST_LEVEL(1'b1)) u_dut (
    .clk(clk), .rst(rst), .irq_lines({lines[31:1], s_irq}), .bus_wr(d_wr), .bus_addr(d_addr),
    .bus_wdata(d_wdata), .bus_rdata(d_rdata), .cpu_irq(d_irq), .cpu_fiq(d_fiq));

  irq_bank_ctrl #(.FIRST_LEVEL(1'b0)) u_sec (
    .clk(clk), .rst(rst), .irq_lines(sec_lines), .bus_wr(s_wr), .bus_addr(s_addr),
    .bus_wdata(s_wdata), .bus_rdata(s_rdata), .cpu_irq(s_irq), .cpu_fiq(s_fiq));

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  int tb_prio [32];
  bit tb_fiq  [32];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FIAL_GUARD");
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sec, input int a, input logic [31:0] v);
    @(negedge clk);
    if (sec) begin s_wr = 1; s_addr = a[7:0]; s_wdata = v; end
    else     begin d_wr = 1; d_addr = a[7:0]; d_wdata = v; end
    @(negedge clk);
    s_wr = 0; d_wr = 0;
  endtask

  task automatic rd(input bit sec, input int a, output logic [31:0] v);
    @(negedge clk);
    if (sec) s_addr = a[7:0]; else d_addr = a[7:0];
    @(negedge clk);
    v = sec ? s_rdata : d_rdata;
  endtask

  function automatic int exp_pick(input logic [31:0] c, output int pr);
    int w = -1;
    pr = 0;
    for (int i = 0; i < 32; i++)
      if (c[i] && (w < 0 || tb_prio[i] < pr)) begin w = i; pr = tb_prio[i]; end
    return w;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    waitc(3);
    rst = 0;
    waitc(2);

    // R1 reset state
    rd(0, 'h04, v); check("R1 mask reset", v, 32'hFFFF_FFFF);
    rd(0, 'hA0, v); check("R1 gmask reset", v, 1);
    rd(0, 'h1C, v); check("R1 cfg reset", v, 0);
    check("R1 irq low", d_irq, 0);
    check("R1 fiq low", d_fiq, 0);

    // R3 layout: other bits read zero
    wr(0, 'h1C + 4*7, 32'hFFFF_FFFF);
    rd(0, 'h1C + 4*7, v); check("R3 cfg readback", v, 32'h7F);

    // Random phase: R4, R5, R2, R6 with both outputs
    wr(0, 'hA0, 0);
    tb_prio[0] = 0; tb_fiq[0] = 0;
    wr(0, 'h1C, 0);
    for (int n = 1; n < 32; n++) begin
      tb_prio[n] = int'($urandom % 32);
      tb_fiq[n]  = 1'($urandom % 2);
      wr(0, 'h1C + 4*n, (tb_prio[n] << 2) | int'(tb_fiq[n]));
    end
    for (int it = 0; it < 14; it++) begin
      logic [31:0] stim, m, el, fv;
      int wi, pi, wf, pf;
      stim = $urandom & 32'hFFFF_FFFE;
      m    = (it % 3 == 0) ? $urandom : 32'h0;
      for (int n = 0; n < 32; n++) fv[n] = tb_fiq[n];
      el = stim & ~m;
      wi = exp_pick(el & ~fv, pi);
      wf = exp_pick(el & fv, pf);
      wr(0, 'h04, m);
      lines = stim;
      waitc(4);
      check("R4 random irq out", d_irq, int'(wi >= 0));
      check("R4 random fiq out", d_fiq, int'(wf >= 0));
      if (wi >= 0) begin rd(0, 'h10, v); check("R5 random irq src", v, (pi << 8) | wi); end
      if (wf >= 0) begin rd(0, 'h14, v); check("R5 random fiq src", v, (pf << 8) | wf); end
      lines = '0;
      waitc(2);
      wr(0, 'h18, 3);
      waitc(3);
      check("R6 random release irq", d_irq, 0);
      check("R6 random release fiq", d_fiq, 0);
    end
    wr(0, 'h04, 32'hFFFF_FFFF);

    // R7 edge line: latched, then cleared by acknowledge
    tb_prio[5] = 3;
    wr(0, 'h1C + 4*5, (3 << 2) | 2);
    wr(0, 'h04, ~(32'h1 << 5));
    @(negedge clk); lines[5] = 1; @(negedge clk); lines[5] = 0;
    waitc(4);
    check("R7 edge raises irq", d_irq, 1);
    rd(0, 'h10, v); check("R7 edge src", v, 32'h305);
    rd(0, 'h00, v); check("R7 edge latched", int'(v[5]), 1);
    wr(0, 'h18, 1);
    waitc(2);
    rd(0, 'h00, v); check("R7 edge cleared by ack", int'(v[5]), 0);
    check("R7 irq low after ack", d_irq, 0);

    // R7 level line follows input and is retaken while high
    wr(0, 'h1C + 4*6, 4 << 2);
    wr(0, 'h04, ~(32'h1 << 6));
    lines[6] = 1;
    waitc(4);
    rd(0, 'h00, v); check("R7 level pending", int'(v[6]), 1);
    wr(0, 'h18, 1);
    waitc(3);
    check("R7 level retaken", d_irq, 1);
    lines[6] = 0;
    waitc(1);
    wr(0, 'h18, 1);
    waitc(3);
    check("R7 level released", d_irq, 0);
    rd(0, 'h00, v); check("R7 level pending follows", int'(v[6]), 0);

    // R8 + R2: masked edge latch visible, cleared by pending write
    wr(0, 'h04, 32'hFFFF_FFFF);
    @(negedge clk); lines[5] = 1; @(negedge clk); lines[5] = 0;
    waitc(3);
    rd(0, 'h00, v); check("R2 masked still pending", int'(v[5]), 1);
    check("R2 masked no irq", d_irq, 0);
    wr(0, 'h00, 0);
    rd(0, 'h00, v); check("R8 pending write clears", int'(v[5]), 0);

    // R4 tie -> lowest line
    wr(0, 'h1C + 4*12, 2 << 2);
    wr(0, 'h1C + 4*13, 2 << 2);
    wr(0, 'h04, ~(32'h3 << 12));
    lines[12] = 1; lines[13] = 1;
    waitc(4);
    rd(0, 'h10, v); check("R4 tie lowest line", v, 32'h20C);
    lines = '0; waitc(1); wr(0, 'h18, 1); waitc(3);

    // R4 priority 0 side wins over line order
    wr(0, 'h1C + 4*14, 9 << 2);
    wr(0, 'h1C + 4*20, 1 << 2);
    wr(0, 'h04, ~((32'h1 << 14) | (32'h1 << 20)));
    lines[14] = 1; lines[20] = 1;
    waitc(4);
    rd(0, 'h10, v); check("R4 lower prio value wins", v, 32'h114);
    lines = '0; waitc(1); wr(0, 'h18, 1); waitc(3);

    // R5 freeze until acknowledge
    wr(0, 'h1C + 4*10, 8 << 2);
    wr(0, 'h1C + 4*11, 1 << 2);
    wr(0, 'h04, ~(32'h3 << 10));
    lines[10] = 1;
    waitc(4);
    rd(0, 'h10, v); check("R5 first winner", v, 32'h80A);
    lines[11] = 1;
    waitc(4);
    rd(0, 'h10, v); check("R5 frozen", v, 32'h80A);
    wr(0, 'h18, 1);
    waitc(4);
    rd(0, 'h10, v); check("R5 new winner after ack", v, 32'h10B);
    lines = '0; waitc(1); wr(0, 'h18, 1); waitc(3);
    check("R6 irq released", d_irq, 0);

    // R6 fast path acknowledge is separate
    wr(0, 'h1C + 4*9, (5 << 2) | 1);
    wr(0, 'h04, ~(32'h1 << 9));
    lines[9] = 1;
    waitc(4);
    check("R6 fiq raised", d_fiq, 1);
    check("R6 irq not raised", d_irq, 0);
    rd(0, 'h14, v); check("R5 fiq src", v, 32'h509);
    lines = '0;
    wr(0, 'h18, 1);
    waitc(3);
    check("R6 irq ack leaves fiq", d_fiq, 1);
    wr(0, 'h18, 2);
    waitc(3);
    check("R6 fiq ack releases", d_fiq, 0);

    // R9 global mask
    wr(0, 'h04, ~(32'h1 << 6));
    lines[6] = 1;
    wr(0, 'hA0, 1);
    waitc(4);
    check("R9 gmask holds low", d_irq, 0);
    wr(0, 'hA0, 0);
    waitc(4);
    check("R9 gmask cleared", d_irq, 1);
    lines = '0; waitc(1); wr(0, 'h18, 1); waitc(3);

    // R10 secondary bank discards fast routing
    wr(1, 'h1C + 4*3, 32'h7F);
    rd(1, 'h1C + 4*3, v); check("R10 fiq bit reads 0", v, 32'h7E);
    wr(1, 'h04, ~(32'h1 << 3));
    wr(1, 'hA0, 0);
    wr(0, 'h1C, 0);
    wr(0, 'h04, 32'hFFFF_FFFE);
    sec_lines[3] = 1;
    waitc(5);
    check("R10 secondary irq", s_irq, 1);
    check("R10 secondary fiq low", s_fiq, 0);
    rd(1, 'h10, v); check("R10 secondary src", v, 32'h1F03);

    // R11 cascade
    check("R11 first-level irq from cascade", d_irq, 1);
    rd(0, 'h10, v); check("R11 cascade line 0", v, 0);
    sec_lines = '0;
    wr(1, 'h18, 1);
    waitc(3);
    check("R11 secondary released", s_irq, 0);
    wr(0, 'h18, 1);
    waitc(3);
    check("R11 first-level released", d_irq, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule